// File: doc/BRIEF.md
# Audio Controller Interrupt and Status Register Bank

This block is a small byte-addressed register bank inside a multi-source audio controller. It collects one-cycle event pulses from eight audio and modem sources into an interrupt-status byte. Software clears those flags by writing ones. It also presents a read-only link status byte, which shows codec-mixer busy, mixer read-data ready, modem-out busy and the non-empty state of four FIFOs. A third byte, the extended status, holds a MIDI interrupt flag that clears when the byte is read, and a byte-pointer flip-flop. That flip-flop toggles on every access to a trapped data port, so a driver that emulates 16-bit registers with 8-bit accesses can tell low bytes from high bytes.

A single active-high interrupt line is raised while any flag is pending, or while the sound-core interrupt input is high. The host port is a simple strobe interface. Read data is combinational from the current register state. Every state change, including the side effects of reads, takes place at the clock edge that ends the access.

Top module: `audio_irq_status`

## Requirements
- R1: After reset, the interrupt-status byte (offset 1) and the extended status byte (offset 2) read 0x00, the byte pointer is 0, and `irq` is low when `sb_core_irq` is low.
- R2: A one-cycle pulse on `irq_evt[i]` sets bit i of the interrupt-status byte at offset 1. The bits are: bit 7 sound/MIDI core, bit 6 DRAM, bit 5 sound mixer, bit 4 mic-in, bit 3 PCI play, bit 2 PCI record, bit 1 modem-in, bit 0 ring-in.
- R3: A host write to offset 1 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R4: When a set pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: The link status byte at offset 0 reads as follows: bit 7 = `mixer_busy`, bit 6 = mixer data ready, bit 5 = `modem_out_busy`, bit 4 = 0, bits 3:0 = `fifo_nonempty[3:0]` (bit 3 PCI out, bit 2 PCI in, bit 1 mic-in, bit 0 DRAM).
- R6: A pulse on `mixer_data_evt` sets the data-ready bit. The bit is cleared only by a write to offset 7 (the top byte of the codec-access register at offsets 4 to 7) with data bit 7 equal to 1. Any other write to offsets 4 to 7 leaves it unchanged. If a set pulse arrives in the same cycle as the clear, the bit stays set.
- R7: In the extended status byte at offset 2, bit 4 is the MIDI flag, bit 0 is the byte pointer, and all other bits read 0. `midi_evt` sets the MIDI flag. A host read of offset 2 returns the flag and then clears it. If `midi_evt` arrives in the same cycle as that read, the flag stays set.
- R8: Every host access, read or write, to offset 8 (the trapped data port) toggles the byte pointer. Accesses to other offsets leave it unchanged.
- R9: `irq` is high exactly when any interrupt-status flag, the MIDI flag, or `sb_core_irq` is high. `sb_core_irq` drives `irq` directly and does not set status bit 7.
- R10: Host writes to the read-only offsets 0 and 2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| irq_evt | input | 8 | One-cycle set pulses for the interrupt-status flags |
| sb_core_irq | input | 1 | Sound-core interrupt level, routed straight to `irq` |
| midi_evt | input | 1 | One-cycle set pulse for the extended MIDI flag |
| mixer_data_evt | input | 1 | One-cycle pulse: mixer read data is available |
| mixer_busy | input | 1 | Codec mixer busy level |
| modem_out_busy | input | 1 | Modem-out path busy level |
| fifo_nonempty | input | 4 | FIFO non-empty levels: PCI out, PCI in, mic-in, DRAM |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong flag value becomes visible on `irq` in the cycle after the faulty edge. It also shows on `host_rdata` as soon as the host sets the address, because read data has no pipeline stage. Clearing faults are the hardest to see, since a lost set pulse looks like an idle source. The bench therefore drives a set and a clear into the same cycle and reads the flag back on the next cycle. A byte pointer that gets out of step does not show on `irq` at all. It shows only in bit 0 of the extended byte, so that bit is checked after trapped reads, after trapped writes, and after accesses to other offsets.

// File: rtl/audio_irq_status.sv
module audio_irq_status #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_LINK  = 4'd0,
  parameter logic [ADDR_W-1:0] A_IRQ   = 4'd1,
  parameter logic [ADDR_W-1:0] A_EXT   = 4'd2,
  parameter logic [ADDR_W-1:0] A_CODEC = 4'd7,
  parameter logic [ADDR_W-1:0] A_TRAP  = 4'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [7:0]        irq_evt,
  input  logic              sb_core_irq,
  input  logic              midi_evt,
  input  logic              mixer_data_evt,
  input  logic              mixer_busy,
  input  logic              modem_out_busy,
  input  logic [3:0]        fifo_nonempty,
  output logic              irq
);

  logic [7:0] irq_flags;
  logic       data_rdy;
  logic       midi_flag;
  logic       byte_ptr;

  wire wr_en     = host_sel & host_wr;
  wire rd_en     = host_sel & ~host_wr;
  wire [7:0] w1c = (wr_en && host_addr == A_IRQ) ? host_wdata : 8'h00;
  wire rdy_clr   = wr_en && host_addr == A_CODEC && host_wdata[7];
  wire midi_rd   = rd_en && host_addr == A_EXT;
  wire trap_acc  = host_sel && host_addr == A_TRAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_flags <= '0;
      data_rdy  <= 1'b0;
      midi_flag <= 1'b0;
      byte_ptr  <= 1'b0;
    end else begin
      irq_flags <= (irq_flags & ~w1c) | irq_evt;
      data_rdy  <= mixer_data_evt | (data_rdy & ~rdy_clr);
      midi_flag <= midi_evt | (midi_flag & ~midi_rd);
      byte_ptr  <= byte_ptr ^ trap_acc;
    end
  end

  wire [7:0] link_stat = {mixer_busy, data_rdy, modem_out_busy, 1'b0, fifo_nonempty};
  wire [7:0] ext_stat  = {3'b000, midi_flag, 3'b000, byte_ptr};

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr == A_LINK) host_rdata = link_stat;
    if (host_addr == A_IRQ)  host_rdata = irq_flags;
    if (host_addr == A_EXT)  host_rdata = ext_stat;
  end

  assign irq = (|irq_flags) | midi_flag | sb_core_irq;

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c & ~irq_evt)) |=> ((irq_flags & $past(w1c & ~irq_evt)) == 8'h00));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt) |=> ((irq_flags & $past(irq_evt)) == $past(irq_evt)));
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && host_addr == A_IRQ)) |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));
  a_r6_rdy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_clr && !mixer_data_evt) |=> !data_rdy);
  a_r7_midi_set: assert property (@(posedge clk) disable iff (!rst_n)
    midi_evt |=> midi_flag);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (midi_rd && !midi_evt) |=> !midi_flag);
  a_r8_ptr_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    trap_acc |=> (byte_ptr != $past(byte_ptr)));
  a_r8_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_acc |=> $stable(byte_ptr));
  a_r9_core_irq: assert property (@(posedge clk) disable iff (!rst_n)
    sb_core_irq |-> irq);

endmodule

// File: tb/tb_audio_irq_status.sv
module tb_audio_irq_status;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       host_sel = 0, host_wr = 0;
  logic [3:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic [7:0] irq_evt = 0;
  logic       sb_core_irq = 0, midi_evt = 0, mixer_data_evt = 0;
  logic       mixer_busy = 0, modem_out_busy = 0;
  logic [3:0] fifo_nonempty = 0;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_irq_status dut (.*);

  // {mixer_busy, modem_out_busy, fifo_nonempty, expected link byte}
  localparam logic [13:0] LINK_VEC [8] = '{
    {1'b1, 1'b0, 4'h0, 8'h80}, {1'b0, 1'b1, 4'h0, 8'h20},
    {1'b0, 1'b0, 4'h1, 8'h01}, {1'b0, 1'b0, 4'h2, 8'h02},
    {1'b0, 1'b0, 4'h4, 8'h04}, {1'b0, 1'b0, 4'h8, 8'h08},
    {1'b1, 1'b1, 4'hF, 8'hAF}, {1'b0, 1'b0, 4'hA, 8'h0A}};

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(logic sel, logic wr, logic [3:0] a, logic [7:0] d,
                     logic [7:0] ev = 0, logic mev = 0, logic dev = 0);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_addr = a; host_wdata = d;
    irq_evt = ev; midi_evt = mev; mixer_data_evt = dev;
    @(posedge clk); #1;
    host_sel = 0; host_wr = 0; irq_evt = 0; midi_evt = 0; mixer_data_evt = 0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    host_sel = 0; host_addr = a; #1;
    v = host_rdata;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v, input logic mev = 0);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a; midi_evt = mev; #1;
    v = host_rdata;
    @(posedge clk); #1;
    host_sel = 0; midi_evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    peek(4'd1, v); chk("R1 irq status", v, 8'h00);
    peek(4'd2, v); chk("R1 ext status", v, 8'h00);
    chk("R1 irq low", {7'd0, irq}, 8'h00);

    foreach (LINK_VEC[i]) begin
      @(negedge clk);
      mixer_busy = LINK_VEC[i][13]; modem_out_busy = LINK_VEC[i][12];
      fifo_nonempty = LINK_VEC[i][11:8];
      peek(4'd0, v); chk("R5 link byte", v, LINK_VEC[i][7:0]);
    end
    mixer_busy = 0; modem_out_busy = 0; fifo_nonempty = 0;

    cyc(0, 0, 0, 0, 8'h05);
    peek(4'd1, v); chk("R2 set flags", v, 8'h05);
    chk("R9 irq from flags", {7'd0, irq}, 8'h01);
    cyc(0, 0, 0, 0, 8'hF0);
    peek(4'd1, v); chk("R2 accumulate", v, 8'hF5);
    cyc(1, 1, 4'd1, 8'h04);
    peek(4'd1, v); chk("R3 w1c", v, 8'hF1);
    cyc(1, 1, 4'd1, 8'h00);
    peek(4'd1, v); chk("R3 zero keeps", v, 8'hF1);
    cyc(1, 1, 4'd1, 8'h80, 8'h80);
    peek(4'd1, v); chk("R4 set wins", v, 8'hF1);
    cyc(1, 1, 4'd0, 8'hFF);
    cyc(1, 1, 4'd2, 8'hFF);
    peek(4'd1, v); chk("R10 ro write irq", v, 8'hF1);
    peek(4'd2, v); chk("R10 ro write ext", v, 8'h00);
    cyc(1, 1, 4'd1, 8'hFF);
    peek(4'd1, v); chk("R3 clear all", v, 8'h00);
    chk("R9 irq idle", {7'd0, irq}, 8'h00);

    @(negedge clk); sb_core_irq = 1; #1;
    chk("R9 core irq direct", {7'd0, irq}, 8'h01);
    peek(4'd1, v); chk("R9 core irq not flagged", v, 8'h00);
    @(negedge clk); sb_core_irq = 0;

    cyc(0, 0, 0, 0, 0, 0, 1);
    peek(4'd0, v); chk("R6 data ready set", v, 8'h40);
    cyc(1, 1, 4'd4, 8'hFF);
    cyc(1, 1, 4'd7, 8'h7F);
    peek(4'd0, v); chk("R6 other writes keep", v, 8'h40);
    cyc(1, 1, 4'd7, 8'h80);
    peek(4'd0, v); chk("R6 clear", v, 8'h00);
    cyc(1, 1, 4'd7, 8'h80, 0, 0, 1);
    peek(4'd0, v); chk("R6 set wins", v, 8'h40);
    cyc(1, 1, 4'd7, 8'h80);

    cyc(0, 0, 0, 0, 0, 1);
    peek(4'd2, v); chk("R7 midi set", v, 8'h10);
    chk("R9 irq midi", {7'd0, irq}, 8'h01);
    rd(4'd2, v); chk("R7 read returns", v, 8'h10);
    peek(4'd2, v); chk("R7 read clears", v, 8'h00);
    cyc(0, 0, 0, 0, 0, 1);
    rd(4'd2, v, 1); chk("R7 read with set", v, 8'h10);
    peek(4'd2, v); chk("R7 flag kept", v, 8'h10);
    rd(4'd2, v);

    rd(4'd8, v);
    peek(4'd2, v); chk("R8 ptr after read", v, 8'h01);
    cyc(1, 1, 4'd9, 8'h55);
    rd(4'd3, v);
    peek(4'd2, v); chk("R8 other offsets keep", v, 8'h01);
    cyc(1, 1, 4'd8, 8'h00);
    peek(4'd2, v); chk("R8 ptr after write", v, 8'h00);

    cyc(0, 0, 0, 0, 8'hFF, 1, 1);
    rd(4'd8, v);
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    peek(4'd1, v); chk("R1 reset irq", v, 8'h00);
    peek(4'd2, v); chk("R1 reset ext", v, 8'h00);
    peek(4'd0, v); chk("R1 reset link", v, 8'h00);
    chk("R1 reset irq out", {7'd0, irq}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule